// File: doc/BRIEF.md
# Repeated String Operation Sequencer

This block runs one string primitive of a 16-bit processor: move, compare, scan, load or store. It runs the primitive once, or many times when a repeat prefix is given. On `start` it captures the operation, the prefix, the element size, the direction flag, both segment bases, the two index registers, the count and the accumulator. It then makes byte or word requests on a memory port that waits for a ready handshake. When the instruction ends it raises `done` for one cycle. In that same cycle the final index registers, count and flags are on its outputs.

Load returns the element it read through an accumulator write port. Compare and scan set a zero flag and a carry flag from their own subtraction. Under the two conditional repeat prefixes the zero flag decides, together with the count, whether another element runs.

Top module: `strop_seq`

## Requirements
- R1: After each element an index register that the operation uses moves by 1 for a byte or 2 for a word. It moves up when `dir_i`=0 and down when `dir_i`=1.
- R2: Source accesses go to `seg_src_i`*16 + SI and destination accesses to `seg_dst_i`*16 + DI. Each address is kept to its low 20 bits.
- R3: Move (`op_i`=0) reads the source element, then writes it to the destination, and steps both SI and DI.
- R4: Load (`op_i`=3) reads the source element and presents it on `acc_wdata_o` with a one-cycle `acc_we_o`. It steps SI only and leaves DI unchanged.
- R5: Store (`op_i`=4) writes the accumulator to the destination, steps DI only and leaves SI unchanged.
- R6: Compare (`op_i`=1) weighs the source element against the destination element. Scan (`op_i`=2) weighs the accumulator against the destination element. `cf_o`=1 when the first is unsigned-below the second, and `zf_o`=1 when they are equal. A byte element uses only bits 7:0. Other operations leave the flags alone.
- R7: With `rep_i`=1 the primitive runs `cx_i` times, and CX drops by one per element. Compare and scan ignore the zero flag for termination in this mode.
- R8: With `rep_i`=2 (while equal) a compare or scan also stops after an element that clears ZF. With `rep_i`=3 (while not equal) it stops after an element that sets ZF.
- R9: Under any repeat prefix, a count of zero ends the instruction with no memory request. SI, DI, CX and the flags are left unchanged.
- R10: With `rep_i`=0 the primitive runs exactly once and CX keeps its start value.
- R11: A memory request holds its address, direction and data stable until `mem_rdy_i` is seen. Word elements use one request with `mem_wide_o`=1 and are little-endian.
- R12: `done_o` is a one-cycle pulse. It comes once per instruction, with the final SI, DI, CX, ZF and CF already on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin an instruction (taken only when idle) |
| op_i | input | 3 | Primitive: 0 move, 1 compare, 2 scan, 3 load, 4 store |
| rep_i | input | 2 | Prefix: 0 none, 1 count only, 2 while equal, 3 while not equal |
| wide_i | input | 1 | 1 for word elements, 0 for byte elements |
| dir_i | input | 1 | Direction flag: 0 increments, 1 decrements |
| seg_src_i | input | 16 | Source segment base |
| seg_dst_i | input | 16 | Destination segment base |
| si_i | input | 16 | Starting source index |
| di_i | input | 16 | Starting destination index |
| cx_i | input | 16 | Starting count |
| acc_i | input | 16 | Accumulator value |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_wide_o | output | 1 | Access size, 1 for word |
| mem_addr_o | output | 20 | Physical byte address |
| mem_wdata_o | output | 16 | Write data, byte in bits 7:0 |
| mem_rdata_i | input | 16 | Read data, byte in bits 7:0 |
| mem_rdy_i | input | 1 | Access completes in this cycle |
| acc_we_o | output | 1 | Accumulator write strobe (load) |
| acc_wide_o | output | 1 | Accumulator write size |
| acc_wdata_o | output | 16 | Accumulator write value |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Instruction finished |
| si_o | output | 16 | Current source index |
| di_o | output | 16 | Current destination index |
| cx_o | output | 16 | Current count |
| zf_o | output | 1 | Zero flag |
| cf_o | output | 1 | Carry flag |

## Verification
The hardest cases to reach are the early exits of the two conditional prefixes. They need memory where a mismatch, or a match, sits at a known place part way through a run. Only then do the final count and indices show exactly how many elements ran. The bench sets up a source area and a destination area that match except for two planted bytes. It runs repeated compares and scans into those bytes in both directions, for both element sizes. It varies the ready latency so that the request-hold rule is tested under waits.

// File: rtl/strop_pkg.sv
// Shared encodings for the string operation sequencer.
// Assumes: op and prefix codes are fixed by the instruction decoder upstream.
package strop_pkg;
    typedef enum logic [2:0] {
        OP_MOVE = 3'd0,
        OP_CMPR = 3'd1,
        OP_SCAN = 3'd2,
        OP_LOAD = 3'd3,
        OP_STOR = 3'd4
    } strop_e;

    typedef enum logic [1:0] {
        RP_NONE     = 2'd0,
        RP_ALL      = 2'd1,
        RP_WHILE_EQ = 2'd2,
        RP_WHILE_NE = 2'd3
    } rep_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TEST,
        ST_SRC,
        ST_DST,
        ST_DONE
    } state_e;
endpackage

// File: rtl/strop_agen.sv
// Physical address former: segment shifted left by SEG_SHIFT plus offset.
// Assumes: the result is kept to PAW bits and any carry out is dropped.
module strop_agen #(
    parameter int W         = 16,
    parameter int SEG_SHIFT = 4,
    parameter int PAW       = 20
) (
    input  logic [W-1:0]   seg,
    input  logic [W-1:0]   off,
    output logic [PAW-1:0] addr
);
    localparam int FW = W + SEG_SHIFT;

    logic [FW-1:0] full;

    // Sum the shifted base and the zero-extended offset, then truncate.
    always_comb begin
        full = {seg, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, off};
        addr = full[PAW-1:0];
    end
endmodule

// File: rtl/strop_step.sv
// Index stepper: moves a pointer by one element in the flagged direction.
// Assumes: a word element is two bytes and the pointer wraps modulo 2^W.
module strop_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] ptr,
    input  logic         dir,
    input  logic         wide,
    output logic [W-1:0] nxt
);
    logic [W-1:0] delta;

    // Choose the step size and the direction.
    always_comb begin
        delta = wide ? W'(2) : W'(1);
        nxt   = dir ? (ptr - delta) : (ptr + delta);
    end
endmodule

// File: rtl/strop_cmp.sv
// Flag comparator: the equal and unsigned-below results of a minus b.
// Assumes: byte operands already arrive zero-extended by the caller.
module strop_cmp #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         eq,
    output logic         below
);
    logic [W:0] diff;

    // Borrow of the subtraction gives below; a zero result gives equal.
    always_comb begin
        diff  = {1'b0, a} - {1'b0, b};
        below = diff[W];
        eq    = (diff[W-1:0] == '0);
    end
endmodule

// File: rtl/strop_seq.sv
// String operation sequencer: runs one string primitive, once or under a
// repeat prefix, over a ready-handshake memory port.
// Assumes: inputs are captured on start while idle, and start is ignored
// while busy. Memory read data is valid in the cycle mem_rdy_i is high.
module strop_seq
    import strop_pkg::*;
#(
    parameter int W         = 16,
    parameter int SEG_SHIFT = 4,
    parameter int PAW       = 20
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [2:0]     op_i,
    input  logic [1:0]     rep_i,
    input  logic           wide_i,
    input  logic           dir_i,
    input  logic [W-1:0]   seg_src_i,
    input  logic [W-1:0]   seg_dst_i,
    input  logic [W-1:0]   si_i,
    input  logic [W-1:0]   di_i,
    input  logic [W-1:0]   cx_i,
    input  logic [W-1:0]   acc_i,
    output logic           mem_req_o,
    output logic           mem_we_o,
    output logic           mem_wide_o,
    output logic [PAW-1:0] mem_addr_o,
    output logic [W-1:0]   mem_wdata_o,
    input  logic [W-1:0]   mem_rdata_i,
    input  logic           mem_rdy_i,
    output logic           acc_we_o,
    output logic           acc_wide_o,
    output logic [W-1:0]   acc_wdata_o,
    output logic           busy_o,
    output logic           done_o,
    output logic [W-1:0]   si_o,
    output logic [W-1:0]   di_o,
    output logic [W-1:0]   cx_o,
    output logic           zf_o,
    output logic           cf_o
);
    localparam int BW = W / 2;

    state_e       st;
    strop_e       op_q;
    rep_e         rep_q;
    logic         wide_q, dir_q;
    logic [W-1:0] ss_q, ds_q, si_q, di_q, cx_q, acc_q, tmp_q;
    logic         zf_q, cf_q;

    logic [PAW-1:0] src_addr, dst_addr;
    logic [W-1:0]   si_nxt, di_nxt, cx_dec;
    logic [W-1:0]   rd_val, acc_val, cmp_a;
    logic           eq, below, is_cmp, elem_end, stop_zf, last_elem;

    strop_agen #(.W(W), .SEG_SHIFT(SEG_SHIFT), .PAW(PAW)) u_agen_src (
        .seg(ss_q), .off(si_q), .addr(src_addr));
    strop_agen #(.W(W), .SEG_SHIFT(SEG_SHIFT), .PAW(PAW)) u_agen_dst (
        .seg(ds_q), .off(di_q), .addr(dst_addr));
    strop_step #(.W(W)) u_step_si (
        .ptr(si_q), .dir(dir_q), .wide(wide_q), .nxt(si_nxt));
    strop_step #(.W(W)) u_step_di (
        .ptr(di_q), .dir(dir_q), .wide(wide_q), .nxt(di_nxt));
    strop_cmp #(.W(W)) u_cmp (
        .a(cmp_a), .b(rd_val), .eq(eq), .below(below));

    // Size the read data and the accumulator to the element width.
    always_comb begin
        rd_val  = wide_q ? mem_rdata_i : {{(W-BW){1'b0}}, mem_rdata_i[BW-1:0]};
        acc_val = wide_q ? acc_q       : {{(W-BW){1'b0}}, acc_q[BW-1:0]};
        cmp_a   = (op_q == OP_SCAN) ? acc_val : tmp_q;
    end

    // Element completion and the repeat stop decision.
    always_comb begin
        is_cmp    = (op_q == OP_CMPR) || (op_q == OP_SCAN);
        elem_end  = mem_rdy_i && (st == ST_DST || (st == ST_SRC && op_q == OP_LOAD));
        cx_dec    = cx_q - W'(1);
        stop_zf   = is_cmp && ((rep_q == RP_WHILE_EQ && !eq) ||
                               (rep_q == RP_WHILE_NE && eq));
        last_elem = (rep_q == RP_NONE) || stop_zf || (cx_dec == '0);
    end

    // Memory port and accumulator port drive.
    always_comb begin
        mem_req_o   = (st == ST_SRC) || (st == ST_DST);
        mem_we_o    = (st == ST_DST) && (op_q == OP_MOVE || op_q == OP_STOR);
        mem_wide_o  = wide_q;
        mem_addr_o  = (st == ST_SRC) ? src_addr : dst_addr;
        mem_wdata_o = (op_q == OP_STOR) ? acc_val : tmp_q;
        acc_we_o    = elem_end && (op_q == OP_LOAD);
        acc_wide_o  = wide_q;
        acc_wdata_o = rd_val;
        busy_o      = (st != ST_IDLE);
        done_o      = (st == ST_DONE);
        si_o = si_q; di_o = di_q; cx_o = cx_q; zf_o = zf_q; cf_o = cf_q;
    end

    // Sequencer state, captured operands and architectural results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; op_q <= OP_MOVE; rep_q <= RP_NONE;
            wide_q <= 1'b0; dir_q <= 1'b0;
            ss_q <= '0; ds_q <= '0; si_q <= '0; di_q <= '0;
            cx_q <= '0; acc_q <= '0; tmp_q <= '0;
            zf_q <= 1'b0; cf_q <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (start_i) begin
                    op_q <= strop_e'(op_i); rep_q <= rep_e'(rep_i);
                    wide_q <= wide_i; dir_q <= dir_i;
                    ss_q <= seg_src_i; ds_q <= seg_dst_i;
                    si_q <= si_i; di_q <= di_i; cx_q <= cx_i; acc_q <= acc_i;
                    st <= ST_TEST;
                end
                ST_TEST: begin
                    if (rep_q != RP_NONE && cx_q == '0)
                        st <= ST_DONE;
                    else if (op_q == OP_SCAN || op_q == OP_STOR)
                        st <= ST_DST;
                    else
                        st <= ST_SRC;
                end
                ST_SRC, ST_DST: if (mem_rdy_i) begin
                    if (!elem_end) begin
                        tmp_q <= rd_val;
                        st    <= ST_DST;
                    end else begin
                        if (op_q == OP_MOVE || op_q == OP_CMPR || op_q == OP_LOAD)
                            si_q <= si_nxt;
                        if (op_q != OP_LOAD)
                            di_q <= di_nxt;
                        if (rep_q != RP_NONE)
                            cx_q <= cx_dec;
                        if (is_cmp) begin
                            zf_q <= eq;
                            cf_q <= below;
                        end
                        st <= last_elem ? ST_DONE : ST_TEST;
                    end
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R11: a pending request keeps its address and direction until ready.
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

    // R12: done is a single-cycle pulse.
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: a zero count under a prefix finishes with no memory request.
    p_zero_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TEST && rep_q != RP_NONE && cx_q == '0) |=> (done_o && !mem_req_o));

    // R10: without a prefix the count is never touched while busy.
    p_cx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && rep_q == RP_NONE) |=> $stable(cx_q));

    // R4: the accumulator write of a load leaves DI where it was.
    p_load_di_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we_o |=> $stable(di_o));

    // R12: results may change only while busy.
    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(si_o) && $stable(di_o) && $stable(cx_o)));
endmodule

// File: tb/sim_strop_seq.sv
module sim_strop_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  rep = '0;
    logic        wide = 1'b0, dir = 1'b0;
    logic [15:0] ss = 16'h0010, ds = 16'h0020;
    logic [15:0] si = '0, di = '0, cx = '0, acc = '0;
    logic        mem_req, mem_we, mem_wide, acc_we, acc_wide, busy, done, zf, cf;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata, acc_wdata, si_o, di_o, cx_o;
    logic        mem_rdy = 1'b0;

    int nchk = 0, nfail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    strop_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .rep_i(rep),
        .wide_i(wide), .dir_i(dir), .seg_src_i(ss), .seg_dst_i(ds),
        .si_i(si), .di_i(di), .cx_i(cx), .acc_i(acc),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_wide_o(mem_wide),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .mem_rdy_i(mem_rdy), .acc_we_o(acc_we), .acc_wide_o(acc_wide),
        .acc_wdata_o(acc_wdata), .busy_o(busy), .done_o(done),
        .si_o(si_o), .di_o(di_o), .cx_o(cx_o), .zf_o(zf), .cf_o(cf));

    // Memory model: 1 KiB little-endian, with a programmable ready latency.
    logic [7:0]  mem [0:1023];
    logic        init_req = 1'b0;
    int          lat = 0, wcnt = 0, nacc = 0, viol = 0;
    logic [15:0] last_acc = '0;
    logic [19:0] first_addr = '0;
    bit          got_first = 1'b0;
    logic        p_req = 1'b0, p_rdy = 1'b0;
    logic [19:0] p_addr = '0;

    assign mem_rdata = {mem[(mem_addr[9:0] + 10'd1)], mem[mem_addr[9:0]]};

    always @(posedge clk) begin
        if (init_req) begin
            for (int i = 0; i < 1024; i++) mem[i] <= 8'h00;
            for (int k = 0; k < 32; k++) begin
                mem[256 + k] <= 8'h10 + 8'(k);
                mem[512 + k] <= 8'h10 + 8'(k);
            end
            mem[517] <= 8'hFF;
            mem[520] <= 8'h00;
        end else if (mem_req && mem_rdy && mem_we) begin
            mem[mem_addr[9:0]] <= mem_wdata[7:0];
            if (mem_wide) mem[mem_addr[9:0] + 10'd1] <= mem_wdata[15:8];
        end
        if (!mem_req || mem_rdy) begin
            mem_rdy <= 1'b0;
            wcnt    <= 0;
        end else if (wcnt >= lat) mem_rdy <= 1'b1;
        else wcnt <= wcnt + 1;
        if (mem_req && mem_rdy) nacc <= nacc + 1;
        if (acc_we) last_acc <= acc_wdata;
        if (mem_req && !got_first) begin
            first_addr <= mem_addr;
            got_first  <= 1'b1;
        end
        if (p_req && !p_rdy && (mem_req !== 1'b1 || mem_addr !== p_addr)) viol <= viol + 1;
        p_req  <= mem_req;
        p_rdy  <= mem_rdy;
        p_addr <= mem_addr;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic init_mem();
        @(negedge clk) init_req = 1'b1;
        @(negedge clk) init_req = 1'b0;
    endtask

    // Start one instruction and return at the negedge where done is high.
    task automatic run(input logic [2:0] o, input logic [1:0] r, input logic w,
                       input logic d, input int l, input logic [15:0] s,
                       input logic [15:0] t, input logic [15:0] c, input logic [15:0] a);
        @(negedge clk);
        op = o; rep = r; wide = w; dir = d; lat = l;
        si = s; di = t; cx = c; acc = a;
        nacc = 0; got_first = 1'b0; start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (done !== 1'b1) @(negedge clk);
    endtask

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  rep;
        logic        wide;
        logic        dir;
        logic [1:0]  lat;
        logic [15:0] si, di, cx, acc;
        logic [15:0] e_si, e_di, e_cx;
        logic        fchk, e_zf, e_cf;
        logic [7:0]  e_nacc;
        logic        achk;
        logic [15:0] e_acc;
        logic        mchk;
        logic [11:0] maddr;
        logic [7:0]  mval;
    } vec_t;

    // Memory before each vector: bytes 0x100+k and 0x200+k hold 0x10+k,
    // except 0x205 = FF and 0x208 = 00.
    localparam vec_t VECS [0:14] = '{
        // R8 compare while-equal, byte, up: mismatch at k=5
        '{3'd1, 2'd2, 1'b0, 1'b0, 2'd1, 16'h0000, 16'h0000, 16'd10, 16'h0000,
          16'h0006, 16'h0006, 16'd4, 1'b1, 1'b0, 1'b1, 8'd12, 1'b0, 16'h0, 1'b0, 12'h0, 8'h0},
        // R8 compare while-equal, all equal: count runs out
        '{3'd1, 2'd2, 1'b0, 1'b0, 2'd0, 16'h0000, 16'h0000, 16'd3, 16'h0000,
          16'h0003, 16'h0003, 16'd0, 1'b1, 1'b1, 1'b0, 8'd6, 1'b0, 16'h0, 1'b0, 12'h0, 8'h0},
        // R8 R6 scan while-not-equal, byte: high byte of accumulator ignored
        '{3'd2, 2'd3, 1'b0, 1'b0, 2'd2, 16'h0033, 16'h0000, 16'd20, 16'hFF17,
          16'h0033, 16'h0008, 16'd12, 1'b1, 1'b1, 1'b0, 8'd8, 1'b0, 16'h0, 1'b0, 12'h0, 8'h0},
        // R1 scan while-not-equal, byte, down: no match
        '{3'd2, 2'd3, 1'b0, 1'b1, 2'd0, 16'h0000, 16'h0009, 16'd4, 16'h00FE,
          16'h0000, 16'h0005, 16'd0, 1'b1, 1'b0, 1'b0, 8'd4, 1'b0, 16'h0, 1'b0, 12'h0, 8'h0},
        // R3 R7 move, word, up, three elements
        '{3'd0, 2'd1, 1'b1, 1'b0, 2'd3, 16'h0000, 16'h0010, 16'd3, 16'h0000,
          16'h0006, 16'h0016, 16'd0, 1'b0, 1'b0, 1'b0, 8'd6, 1'b0, 16'h0, 1'b1, 12'h215, 8'h15},
        // R1 R3 move, byte, down
        '{3'd0, 2'd1, 1'b0, 1'b1, 2'd1, 16'h0004, 16'h0014, 16'd2, 16'h0000,
          16'h0002, 16'h0012, 16'd0, 1'b0, 1'b0, 1'b0, 8'd4, 1'b0, 16'h0, 1'b1, 12'h213, 8'h13},
        // R4 R10 load, word, no prefix
        '{3'd3, 2'd0, 1'b1, 1'b0, 2'd0, 16'h0002, 16'h0007, 16'd9, 16'h0000,
          16'h0004, 16'h0007, 16'd9, 1'b0, 1'b0, 1'b0, 8'd1, 1'b1, 16'h1312, 1'b0, 12'h0, 8'h0},
        // R4 load, byte, down, repeated: last element wins
        '{3'd3, 2'd1, 1'b0, 1'b1, 2'd2, 16'h0005, 16'h0040, 16'd2, 16'h0000,
          16'h0003, 16'h0040, 16'd0, 1'b0, 1'b0, 1'b0, 8'd2, 1'b1, 16'h0014, 1'b0, 12'h0, 8'h0},
        // R5 R1 store, word, down
        '{3'd4, 2'd1, 1'b1, 1'b1, 2'd1, 16'h0050, 16'h000A, 16'd2, 16'hBEEF,
          16'h0050, 16'h0006, 16'd0, 1'b0, 1'b0, 1'b0, 8'd2, 1'b0, 16'h0, 1'b1, 12'h209, 8'hBE},
        // R5 R10 store, byte, no prefix
        '{3'd4, 2'd0, 1'b0, 1'b0, 2'd0, 16'h0051, 16'h001F, 16'd5, 16'h1234,
          16'h0051, 16'h0020, 16'd5, 1'b0, 1'b0, 1'b0, 8'd1, 1'b0, 16'h0, 1'b1, 12'h21F, 8'h34},
        // R6 R10 compare, word, no prefix: source above destination
        '{3'd1, 2'd0, 1'b1, 1'b0, 2'd3, 16'h0008, 16'h0008, 16'd7, 16'h0000,
          16'h000A, 16'h000A, 16'd7, 1'b1, 1'b0, 1'b0, 8'd2, 1'b0, 16'h0, 1'b0, 12'h0, 8'h0},
        // R8 compare while-not-equal, word: never equal
        '{3'd1, 2'd3, 1'b1, 1'b0, 2'd0, 16'h0000, 16'h0004, 16'd6, 16'h0000,
          16'h000C, 16'h0010, 16'd0, 1'b1, 1'b0, 1'b1, 8'd12, 1'b0, 16'h0, 1'b0, 12'h0, 8'h0},
        // R8 scan while-equal, word: stops at second element
        '{3'd2, 2'd2, 1'b1, 1'b0, 2'd1, 16'h0000, 16'h0000, 16'd5, 16'h1110,
          16'h0000, 16'h0004, 16'd3, 1'b1, 1'b0, 1'b1, 8'd2, 1'b0, 16'h0, 1'b0, 12'h0, 8'h0},
        // R7 scan with count-only prefix: a match does not stop it
        '{3'd2, 2'd1, 1'b0, 1'b0, 2'd0, 16'h0000, 16'h0000, 16'd3, 16'h0010,
          16'h0000, 16'h0003, 16'd0, 1'b1, 1'b0, 1'b1, 8'd3, 1'b0, 16'h0, 1'b0, 12'h0, 8'h0},
        // R9 zero count: nothing moves, flags kept from the previous vector
        '{3'd1, 2'd2, 1'b0, 1'b0, 2'd0, 16'h0003, 16'h0004, 16'd0, 16'h0000,
          16'h0003, 16'h0004, 16'd0, 1'b1, 1'b0, 1'b1, 8'd0, 1'b0, 16'h0, 1'b0, 12'h0, 8'h0}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 reset done", {31'd0, done}, 32'd0);
        check("R12 reset busy", {31'd0, busy}, 32'd0);
        check("R11 reset req", {31'd0, mem_req}, 32'd0);
        check("R12 reset cx", {16'd0, cx_o}, 32'd0);
        rst_n = 1'b1;

        foreach (VECS[v]) begin
            init_mem();
            run(VECS[v].op, VECS[v].rep, VECS[v].wide, VECS[v].dir, int'(VECS[v].lat),
                VECS[v].si, VECS[v].di, VECS[v].cx, VECS[v].acc);
            check($sformatf("R1 R3 R4 R5 SI v%0d", v), {16'd0, si_o}, {16'd0, VECS[v].e_si});
            check($sformatf("R1 R4 R5 DI v%0d", v), {16'd0, di_o}, {16'd0, VECS[v].e_di});
            check($sformatf("R7 R10 CX v%0d", v), {16'd0, cx_o}, {16'd0, VECS[v].e_cx});
            check($sformatf("R9 access count v%0d", v), nacc, {24'd0, VECS[v].e_nacc});
            if (VECS[v].fchk) begin
                check($sformatf("R6 R8 ZF v%0d", v), {31'd0, zf}, {31'd0, VECS[v].e_zf});
                check($sformatf("R6 R8 CF v%0d", v), {31'd0, cf}, {31'd0, VECS[v].e_cf});
            end
            if (VECS[v].achk)
                check($sformatf("R4 acc write v%0d", v), {16'd0, last_acc}, {16'd0, VECS[v].e_acc});
            @(negedge clk);
            check($sformatf("R12 done pulse v%0d", v), {31'd0, done}, 32'd0);
            if (VECS[v].mchk)
                check($sformatf("R3 R5 memory v%0d", v), {24'd0, mem[VECS[v].maddr[9:0]]},
                      {24'd0, VECS[v].mval});
        end

        // R2 address sum truncated to 20 bits
        init_mem();
        ss = 16'hFFFF;
        run(3'd3, 2'd0, 1'b0, 1'b0, 0, 16'h0025, 16'h0000, 16'd0, 16'h0000);
        check("R2 truncated source address", {12'd0, first_addr}, 32'h00015);
        ss = 16'h0010;
        ds = 16'h0021;
        run(3'd4, 2'd0, 1'b0, 1'b0, 0, 16'h0000, 16'h0003, 16'd0, 16'h00AA);
        check("R2 destination address", {12'd0, first_addr}, 32'h00213);
        ds = 16'h0020;

        // R9 zero count with a move: no write reaches memory
        init_mem();
        run(3'd0, 2'd1, 1'b1, 1'b0, 0, 16'h0000, 16'h0000, 16'd0, 16'h0000);
        check("R9 zero count move accesses", nacc, 32'd0);
        @(negedge clk);
        check("R9 zero count move memory", {24'd0, mem[512]}, 32'h10);

        // R11 no request changed address while waiting
        check("R11 request hold", viol, 32'd0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule